// File: doc/BRIEF.md
# Word-Register Serial Bus Slave

This block is the target side of a two-wire serial bus (I2C / SMBus style) that lets a host reach a bank of eight 16-bit registers held outside the block. Both bus lines are oversampled by the system clock. Each line passes through a two-flop synchronizer and a small majority filter. A single edge detector then produces SCL rise and fall events and START and STOP conditions. The block never stretches the clock and drives SDA only through an open-drain enable, `sda_oe`: when it is 1, the pad pulls SDA low.

The slave address is seven bits. The upper four bits are the fixed code `0011` and the lower three come from strap pins. The eighth bit of the address byte selects the direction, 1 for read and 0 for write. A write carries a pointer byte and a data word, high byte first, and the register port is strobed only when STOP arrives. A read returns the word at the current pointer, high byte first. A selective read sets the pointer with a data-less write and then issues a repeated START. If SCL is held low for too long during a transfer, the slave drops the transfer and releases SDA.

The controller is one state machine with these states:
- `ST_IDLE`: waits for START.
- `ST_RX_ADDR`, `ST_RX_PTR`, `ST_RX_MSB`, `ST_RX_LSB`: shift in one byte each.
- `ST_ACK_ADDR`, `ST_ACK_PTR`, `ST_ACK_MSB`, `ST_ACK_LSB`: pull SDA low for the ninth clock.
- `ST_HOLD`: idles until STOP once a word is complete or the host has declined.
- `ST_TX_BYTE`: shifts a byte out.
- `ST_TX_ACK`: samples the host's acknowledge.

The transitions are:
- START in any state goes to `ST_RX_ADDR`.
- STOP or timeout in any state goes to `ST_IDLE`.
- In `ST_RX_ADDR`, after the eighth bit a matching address goes to `ST_ACK_ADDR` and a mismatch goes to `ST_IDLE`.
- Each `ST_RX_*` state goes to its `ST_ACK_*` state on the SCL fall that ends the eighth bit.
- `ST_ACK_ADDR` goes to `ST_RX_PTR` for a write and to `ST_TX_BYTE` for a read.
- `ST_ACK_PTR` goes to `ST_RX_MSB`, `ST_ACK_MSB` goes to `ST_RX_LSB`, and `ST_ACK_LSB` goes to `ST_HOLD` with the write pending.
- `ST_TX_BYTE` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX_BYTE` with the other byte of the word on an acknowledge, or to `ST_HOLD` on a not-acknowledge.

Top module: `smbus_regslave`

## Requirements
- R1: An address byte acknowledges only when its upper seven bits equal `0011` followed by `strap_i[2:0]`. Any other address leaves `sda_oe` at 0 during the ninth clock.
- R2: The slave pulls SDA low (`sda_oe`=1) through the ninth clock after a matching address and after every pointer and data byte the host writes.
- R3: A write (address with bit0=0, pointer, high byte, low byte) raises `reg_we` for exactly one clock, only after the STOP, with `reg_addr` equal to the pointer and `reg_wdata` equal to {high byte, low byte}. No strobe occurs before the STOP.
- R4: An address with bit0=1 and no pointer byte returns the register at the current pointer, most significant bit first, high byte then low byte. A not-acknowledge followed by STOP ends it.
- R5: A pointer write followed by a repeated START and a read address returns the register at the new pointer and produces no write strobe.
- R6: After reset the pointer is 0x00, `sda_oe` is 0 and `reg_we` is 0.
- R7: SDA is sampled on the SCL rise. The slave changes its SDA drive only after an SCL fall, so its output is stable while SCL is high.
- R8: If SCL stays low for `TIMEOUT_CYC` clocks between START and STOP (the count restarting on every SCL fall), the slave releases SDA, returns to idle, and answers the next transfer normally.
- R9: A pointer value of `NREG` or higher is accepted. A read of it returns 0x0000 and a write to it produces no strobe.
- R10: A write cut short by a repeated START or by a timeout before STOP produces no strobe.
- R11: A pulse on SCL or SDA that lasts a single system clock is removed by the line filter and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Low three address bits from board straps |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | ADDR_W (3) | Register index, low bits of the pointer |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 16 | Word read from the register at `reg_addr` |

## Verification
Every pad edge reaches the state machine about five to six system clocks later: two synchronizer flops, the majority window, its output flop and the edge detector. As a result, an acknowledge or data bit appears on `sda_oe` within roughly seven clocks of the SCL fall that calls for it, and `reg_we` appears within a similar delay after the STOP. The bench holds each SCL half period for 16 clocks and reads SDA in the middle of the high phase, so a response is checked well after it is due and well before the next edge. Write strobes are counted and compared one full half period after the STOP, and a second time just before it, so that an early strobe is also caught. Timeout checks wait `TIMEOUT_CYC` plus a margin after the last SCL fall.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam logic [3:0] SMB_PREAMBLE = 4'b0011;
    localparam int         SMB_WORD_W   = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ACK_ADDR,
        ST_RX_PTR,
        ST_ACK_PTR,
        ST_RX_MSB,
        ST_ACK_MSB,
        ST_RX_LSB,
        ST_ACK_LSB,
        ST_HOLD,
        ST_TX_BYTE,
        ST_TX_ACK
    } smb_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } smb_evt_t;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int   MAJ_TAPS = 3,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W  = $clog2(MAJ_TAPS + 1);
    localparam int THRESH = MAJ_TAPS / 2 + 1;

    logic [1:0]          sync_q;
    logic [MAJ_TAPS-1:0] hist_q;
    logic [CNT_W-1:0]    ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < MAJ_TAPS; i++) begin
            ones = ones + CNT_W'(hist_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RST_VAL}};
            hist_q <= {MAJ_TAPS{RST_VAL}};
            line_o <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[MAJ_TAPS-2:0], sync_q[1]};
            line_o <= (ones >= CNT_W'(THRESH));
        end
    end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import smb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output smb_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
        evt.rise  = scl_f & ~scl_q;
        evt.fall  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic scl_f,
    input  logic scl_fall,
    output logic tmo
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!armed || scl_f || scl_fall) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tmo = armed & ~scl_f & (cnt_q == LAST);
endmodule

// File: rtl/smbus_regslave.sv
module smbus_regslave
    import smb_pkg::*;
#(
    parameter int  NREG        = 8,
    parameter int  MAJ_TAPS    = 3,
    parameter int  TIMEOUT_CYC = 3_000_000,
    localparam int ADDR_W      = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [2:0]            strap_i,
    output logic                  sda_oe,
    output logic [ADDR_W-1:0]     reg_addr,
    output logic [SMB_WORD_W-1:0] reg_wdata,
    output logic                  reg_we,
    input  logic [SMB_WORD_W-1:0] reg_rdata
);
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    logic       scl_f;
    logic       sda_f;
    smb_evt_t   evt;
    logic       tmo;

    smb_state_t            state;
    logic [3:0]            bit_cnt;
    logic [7:0]            rx_sh;
    logic [7:0]            tx_sh;
    logic [SMB_WORD_W-1:0] tx_word;
    logic                  tx_lsb;
    logic                  mack;
    logic                  is_read;
    logic [7:0]            ptr;
    logic [7:0]            wr_msb;
    logic [7:0]            wr_lsb;
    logic                  wr_pend;
    logic                  busy;
    logic                  we_q;
    logic                  ptr_rsvd;
    logic [SMB_WORD_W-1:0] rd_word;
    logic                  addr_hit;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        smb_line_filter #(.MAJ_TAPS(MAJ_TAPS), .RST_VAL(1'b1)) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    smb_bus_events i_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .evt   (evt)
    );

    smb_timeout #(.LIMIT(TIMEOUT_CYC)) i_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (busy),
        .scl_f    (scl_f),
        .scl_fall (evt.fall),
        .tmo      (tmo)
    );

    assign ptr_rsvd = (ptr >= NREG_B);
    assign rd_word  = ptr_rsvd ? '0 : reg_rdata;
    assign addr_hit = (rx_sh[7:1] == {SMB_PREAMBLE, strap_i});

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            tx_word <= '0;
            tx_lsb  <= 1'b0;
            mack    <= 1'b0;
            is_read <= 1'b0;
            ptr     <= '0;
            wr_msb  <= '0;
            wr_lsb  <= '0;
            wr_pend <= 1'b0;
            busy    <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (tmo) begin
                state   <= ST_IDLE;
                busy    <= 1'b0;
                wr_pend <= 1'b0;
                bit_cnt <= '0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                busy    <= 1'b0;
                wr_pend <= 1'b0;
                bit_cnt <= '0;
                if (wr_pend && !ptr_rsvd) begin
                    we_q <= 1'b1;
                end
            end else if (evt.start) begin
                state   <= ST_RX_ADDR;
                busy    <= 1'b1;
                wr_pend <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_HOLD: begin
                    end
                    ST_RX_ADDR, ST_RX_PTR, ST_RX_MSB, ST_RX_LSB: begin
                        if (evt.rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_f};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt.fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_RX_ADDR) begin
                                if (addr_hit) begin
                                    is_read <= rx_sh[0];
                                    state   <= ST_ACK_ADDR;
                                end else begin
                                    state   <= ST_IDLE;
                                end
                            end else if (state == ST_RX_PTR) begin
                                ptr   <= rx_sh;
                                state <= ST_ACK_PTR;
                            end else if (state == ST_RX_MSB) begin
                                wr_msb <= rx_sh;
                                state  <= ST_ACK_MSB;
                            end else begin
                                wr_lsb <= rx_sh;
                                state  <= ST_ACK_LSB;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (evt.fall) begin
                            if (is_read) begin
                                tx_word <= rd_word;
                                tx_sh   <= rd_word[15:8];
                                tx_lsb  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_TX_BYTE;
                            end else begin
                                state   <= ST_RX_PTR;
                            end
                        end
                    end
                    ST_ACK_PTR: begin
                        if (evt.fall) state <= ST_RX_MSB;
                    end
                    ST_ACK_MSB: begin
                        if (evt.fall) state <= ST_RX_LSB;
                    end
                    ST_ACK_LSB: begin
                        if (evt.fall) begin
                            wr_pend <= 1'b1;
                            state   <= ST_HOLD;
                        end
                    end
                    ST_TX_BYTE: begin
                        if (evt.rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (evt.fall) begin
                            if (bit_cnt == 4'd8) begin
                                bit_cnt <= '0;
                                state   <= ST_TX_ACK;
                            end else begin
                                tx_sh <= {tx_sh[6:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.rise) begin
                            mack <= ~sda_f;
                        end else if (evt.fall) begin
                            if (mack) begin
                                tx_sh  <= tx_lsb ? tx_word[15:8] : tx_word[7:0];
                                tx_lsb <= ~tx_lsb;
                                state  <= ST_TX_BYTE;
                            end else begin
                                state  <= ST_HOLD;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_MSB, ST_ACK_LSB: sda_oe = 1'b1;
            ST_TX_BYTE:                                      sda_oe = ~tx_sh[7];
            default:                                         sda_oe = 1'b0;
        endcase
        reg_addr  = ptr[ADDR_W-1:0];
        reg_wdata = {wr_msb, wr_lsb};
        reg_we    = we_q;
    end

    AST_WE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(evt.stop)); // R3
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R3
    AST_WE_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !ptr_rsvd); // R9
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !sda_oe); // R8
    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$past(sda_oe)) |-> !scl_f); // R7
    AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_ADDR) |-> addr_hit); // R1
endmodule

// File: tb/test_smbus_regslave.sv
module test_smbus_regslave;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 16;
    localparam int TMO        = 400;
    localparam int WD_CYC     = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;

    logic [15:0] mem [8];
    int          we_cnt = 0;
    logic [2:0]  last_a;
    logic [15:0] last_d;
    int          total = 0;
    int          bad = 0;
    bit          unstable = 1'b0;

    localparam logic [7:0] AW = 8'h3A;
    localparam logic [7:0] AR = 8'h3B;

    // {read, pointer, data, expected}
    localparam logic [40:0] VEC [9] = '{
        {1'b0, 8'h02, 16'h1234, 16'h1234},
        {1'b0, 8'h05, 16'hBEEF, 16'hBEEF},
        {1'b1, 8'h02, 16'h0000, 16'h1234},
        {1'b1, 8'h05, 16'h0000, 16'hBEEF},
        {1'b0, 8'h0A, 16'h5555, 16'h0000},
        {1'b1, 8'h0A, 16'h0000, 16'h0000},
        {1'b1, 8'h07, 16'h0000, 16'hA777},
        {1'b0, 8'h00, 16'h8001, 16'h8001},
        {1'b1, 8'h00, 16'h0000, 16'h8001}
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smbus_regslave #(.NREG(8), .MAJ_TAPS(3), .TIMEOUT_CYC(TMO)) i_smbus_regslave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .strap_i   (strap),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 16'hA000 | (16'(i) * 16'h0111);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt        <= we_cnt + 1;
            last_a        <= reg_addr;
            last_d        <= reg_wdata;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H / 2);
    endtask

    task automatic bus_rstart;
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H / 2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch) begin
                wait_cyc(H / 2); scl_m = 1'b1; wait_cyc(1); scl_m = 1'b0; wait_cyc(H / 2);
            end else begin
                wait_cyc(H);
            end
            scl_m = 1'b1;
            if (glitch) begin
                wait_cyc(H / 2); sda_m = ~b[i]; wait_cyc(1); sda_m = b[i]; wait_cyc(H / 2);
            end else begin
                wait_cyc(H);
            end
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H / 2);
        ack = ~sda_bus;
        wait_cyc(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic s1;
            sda_m = 1'b1; wait_cyc(H);
            scl_m = 1'b1; wait_cyc(H / 2);
            s1 = sda_bus;
            b[i] = s1;
            wait_cyc(H / 2 - 1);
            if (sda_bus !== s1) unstable = 1'b1;
            wait_cyc(1);
            scl_m = 1'b0;
        end
        sda_m = nack; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] p, input logic [15:0] d, input bit gl, input int inc);
        bit a0, a1, a2, a3;
        int n0;
        n0 = we_cnt;
        bus_start;
        send_byte(AW, gl, a0);
        send_byte(p, gl, a1);
        send_byte(d[15:8], gl, a2);
        send_byte(d[7:0], gl, a3);
        chk(a0 && a1 && a2 && a3, "R2 write bytes acked", {28'd0, a0, a1, a2, a3}, 32'hF);
        wait_cyc(2 * H);
        chk(we_cnt == n0, "R3 no strobe before STOP", we_cnt, n0);
        bus_stop;
        wait_cyc(H);
        chk(we_cnt == n0 + inc, (inc == 0) ? "R9 reserved write no strobe" : "R3 strobe after STOP", we_cnt, n0 + inc);
        if (inc != 0) begin
            chk(last_a == p[2:0] && last_d == d, "R3 strobe addr/data", {13'd0, last_a, last_d}, {13'd0, p[2:0], d});
        end
    endtask

    task automatic sel_read(input logic [7:0] p, output logic [15:0] d, output bit acks);
        bit a0, a1, a2;
        bus_start;
        send_byte(AW, 1'b0, a0);
        send_byte(p, 1'b0, a1);
        bus_rstart;
        send_byte(AR, 1'b0, a2);
        recv_byte(1'b0, d[15:8]);
        recv_byte(1'b1, d[7:0]);
        bus_stop;
        acks = a0 & a1 & a2;
    endtask

    task automatic imm_read(output logic [15:0] d, output bit ack);
        bus_start;
        send_byte(AR, 1'b0, ack);
        recv_byte(1'b0, d[15:8]);
        recv_byte(1'b1, d[7:0]);
        bus_stop;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", WD_CYC);
        summary;
    end

    initial begin
        logic [15:0] rd;
        bit          ak;
        int          n0;
        wait_cyc(5);
        #1;
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R6 reset outputs idle", {30'd0, sda_oe, reg_we}, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        imm_read(rd, ak);
        chk(ak, "R1 matching read address acked", ak, 1);
        chk(rd == 16'hA000, "R6 R4 immediate read at pointer 0", rd, 16'hA000);

        bus_start;
        send_byte(8'h38, 1'b0, ak);
        bus_stop;
        chk(!ak, "R1 foreign address not acked", ak, 0);

        for (int v = 0; v < 9; v++) begin
            logic [40:0] e;
            e = VEC[v];
            if (e[40]) begin
                n0 = we_cnt;
                sel_read(e[39:32], rd, ak);
                chk(ak, "R5 selective read acks", ak, 1);
                chk(rd == e[15:0], (e[39:32] >= 8) ? "R9 reserved read zero" : "R5 selective read data", rd, e[15:0]);
                chk(we_cnt == n0, "R5 read makes no strobe", we_cnt, n0);
            end else begin
                do_write(e[39:32], e[31:16], 1'b0, (e[39:32] < 8) ? 1 : 0);
            end
        end

        // R10: write cut by repeated START
        n0 = we_cnt;
        bus_start;
        send_byte(AW, 1'b0, ak);
        send_byte(8'h03, 1'b0, ak);
        send_byte(8'hDE, 1'b0, ak);
        send_byte(8'hAD, 1'b0, ak);
        bus_rstart;
        send_byte(AR, 1'b0, ak);
        recv_byte(1'b0, rd[15:8]);
        recv_byte(1'b1, rd[7:0]);
        bus_stop;
        wait_cyc(H);
        chk(we_cnt == n0, "R10 repeated START drops write", we_cnt, n0);
        chk(rd == 16'hA333, "R10 register unchanged", rd, 16'hA333);

        // R8 / R10: write cut by timeout
        n0 = we_cnt;
        bus_start;
        send_byte(AW, 1'b0, ak);
        send_byte(8'h04, 1'b0, ak);
        send_byte(8'h12, 1'b0, ak);
        send_byte(8'h34, 1'b0, ak);
        wait_cyc(TMO + 100);
        bus_stop;
        wait_cyc(H);
        chk(we_cnt == n0, "R8 R10 timeout drops write", we_cnt, n0);
        imm_read(rd, ak);
        chk(ak && rd == 16'hA444, "R8 recovers after timeout", {15'd0, ak, rd}, {15'd0, 1'b1, 16'hA444});

        // R8: ACK drive released after SCL held low
        bus_start;
        for (int i = 7; i >= 0; i--) begin
            sda_m = AW[i]; wait_cyc(H);
            scl_m = 1'b1; wait_cyc(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1;
        wait_cyc(2 * H);
        chk(sda_oe == 1'b1, "R2 ACK driven in ninth clock", sda_oe, 1);
        wait_cyc(TMO + 50);
        chk(sda_oe == 1'b0, "R8 SDA released after timeout", sda_oe, 0);
        bus_stop;

        // R11: single-clock glitches on both lines
        do_write(8'h06, 16'h0F0F, 1'b1, 1);
        sel_read(8'h06, rd, ak);
        chk(ak && rd == 16'h0F0F, "R11 glitches filtered", rd, 16'h0F0F);

        chk(!unstable, "R7 slave SDA stable while SCL high", unstable, 0);
        summary;
    end
endmodule